// File: doc/BRIEF.md
# Prescaled CPU-Cycle Interrupt Timer

This block is a down-counter that advances once per CPU cycle, signalled by a per-cycle enable, and raises an active-high interrupt request when it runs out. Software programs it through three write-only registers on a small register-write port. The first is an 8-bit reload latch. The second is a control register that starts or stops counting, masks the request, and carries a hold bit. The third is an acknowledge register: a write to it drops the request and restarts the count.

The reload value is the latch scaled by sixteen. The exact formula depends on what caused the reload. Stopping the counter loads two steps of sixteen above the latch value, or 17 when the latch is zero. An acknowledge loads one step above it, or 1 when the latch is zero. The longest delay that can be scheduled is therefore just over four thousand cycles. The request output is a pending flag gated by the mask bit. Software can produce a second request without acknowledging by clearing the mask bit and then setting it again.

Top module: `cpu_cycle_irq_timer`

## Requirements
- R1: After reset the request output is low, counting is disabled, the pending flag is clear, and both the counter and the latch hold zero. Setting only the mask bit (bit 1) after reset raises no request.
- R2: A write to offset 0xD stores the 8-bit data in the latch. The latch value sets every later reload, and writing it does not change a count already in progress.
- R3: A write to offset 0xE with bit 0 clear stops counting and loads the counter with (L+2)*16, or with 17 when L is zero, where L is the latch.
- R4: Any write to offset 0xF, whatever its data, clears the pending flag and loads the counter with (L+1)*16, or with 1 when L is zero.
- R5: The counter decrements by one only on a clock edge where the cycle enable is high, control bit 0 is 1 and control bit 2 is 0. Edges with the cycle enable low leave it unchanged.
- R6: While control bit 2 is 1, the counter holds its value even with bit 0 set and the cycle enable high.
- R7: A counting edge that finds the counter at 1 or 0 leaves it at 0 and sets the pending flag. With bit 1 set, the request output is high from that edge on. A reload of N with uninterrupted counting therefore raises the request N edges after the reloading write.
- R8: The request output is the pending flag gated by control bit 1. Clearing bit 1 drops the request on the next edge and keeps the pending flag. Setting bit 1 again raises the request without an acknowledge.
- R9: A write to offset 0xE or 0xF takes precedence over a count on the same edge, and that count is lost. Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuTick | input | 1 | High for one clock per CPU cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register offset within the block window |
| wrData | input | 8 | Write data |
| irqReq | output | 1 | Interrupt request, active high |

## Verification
A write takes effect on the clock edge that samples it. A request expires N counting edges after the write that loaded N, and it is seen on the request output after that same edge, because the output is a gate on registered state. The bench drives every input at falling edges and reads the output at the next falling edge. After each reloading write, it counts falling edges until the request appears and compares the count with N. Mask changes and acknowledges are checked one edge after their write. Hold and idle-enable intervals are checked after a fixed run of edges with no expected change.

// File: rtl/cpu_cycle_irq_timer_pkg.sv
package cpu_cycle_irq_timer_pkg;

  // Strobes passed from the register decoder to the counter datapath.
  typedef struct packed {
    logic latchWr;     // store write data into the reload latch
    logic stopReload;  // counter stopped: load the long reload value
    logic ackReload;   // acknowledge: clear pending, load the short reload value
    logic countStep;   // counting edge
  } timerStrobes_t;

  // Control register bit positions (software-visible encoding).
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_MASK_BIT = 1;
  localparam int unsigned CTRL_HOLD_BIT = 2;

endpackage

// File: rtl/cpu_cycle_irq_timer_ctrl.sv
module cpu_cycle_irq_timer_ctrl
  import cpu_cycle_irq_timer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] LATCH_OFS = 4'hD,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 4'hE,
  parameter logic [ADDR_W-1:0] ACK_OFS   = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output timerStrobes_t     strobes,
  output logic              reqEnable,
  output logic              holdBit
);

  logic runBit;
  logic latchHit;
  logic ctrlHit;
  logic ackHit;

  assign latchHit = wrEn && (wrAddr == LATCH_OFS);
  assign ctrlHit  = wrEn && (wrAddr == CTRL_OFS);
  assign ackHit   = wrEn && (wrAddr == ACK_OFS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      reqEnable <= 1'b0;
      holdBit   <= 1'b0;
    end else if (ctrlHit) begin
      runBit    <= wrData[CTRL_RUN_BIT];
      reqEnable <= wrData[CTRL_MASK_BIT];
      holdBit   <= wrData[CTRL_HOLD_BIT];
    end
  end

  // A control or acknowledge write owns the edge; the count on that edge is dropped.
  always_comb begin
    strobes.latchWr    = latchHit;
    strobes.stopReload = ctrlHit && !wrData[CTRL_RUN_BIT];
    strobes.ackReload  = ackHit;
    strobes.countStep  = cpuTick && runBit && !holdBit && !ctrlHit && !ackHit;
  end

endmodule

// File: rtl/cpu_cycle_irq_timer_dp.sv
module cpu_cycle_irq_timer_dp
  import cpu_cycle_irq_timer_pkg::*;
#(
  parameter int unsigned LATCH_W  = 8,
  parameter int unsigned SCALE_SH = 4,
  parameter int unsigned CNT_W    = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  timerStrobes_t      strobes,
  input  logic [LATCH_W-1:0] wrData,
  output logic [LATCH_W-1:0] latchVal,
  output logic [CNT_W-1:0]   countVal,
  output logic               pendingFlag
);

  localparam logic [CNT_W-1:0] STOP_ZERO_VAL = CNT_W'((1 << SCALE_SH) + 1);
  localparam logic [CNT_W-1:0] ACK_ZERO_VAL  = CNT_W'(1);

  logic [CNT_W-1:0] stopVal;
  logic [CNT_W-1:0] ackVal;
  logic             latchZero;
  logic             atLastStep;

  assign latchZero  = (latchVal == '0);
  assign stopVal    = latchZero ? STOP_ZERO_VAL
                                : ((CNT_W'(latchVal) + CNT_W'(2)) << SCALE_SH);
  assign ackVal     = latchZero ? ACK_ZERO_VAL
                                : ((CNT_W'(latchVal) + CNT_W'(1)) << SCALE_SH);
  assign atLastStep = (countVal <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchVal <= '0;
    else if (strobes.latchWr) latchVal <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobes.stopReload) begin
      countVal <= stopVal;
    end else if (strobes.ackReload) begin
      countVal <= ackVal;
    end else if (strobes.countStep && (countVal != '0)) begin
      countVal <= countVal - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingFlag <= 1'b0;
    end else if (strobes.ackReload) begin
      pendingFlag <= 1'b0;
    end else if (strobes.countStep && atLastStep) begin
      pendingFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/cpu_cycle_irq_timer.sv
module cpu_cycle_irq_timer
  import cpu_cycle_irq_timer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned LATCH_W  = 8,
  parameter int unsigned SCALE_SH = 4,
  parameter logic [ADDR_W-1:0] LATCH_OFS = 4'hD,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 4'hE,
  parameter logic [ADDR_W-1:0] ACK_OFS   = 4'hF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuTick,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [LATCH_W-1:0] wrData,
  output logic               irqReq
);

  localparam int unsigned MAX_RELOAD = ((1 << LATCH_W) + 1) << SCALE_SH;
  localparam int unsigned CNT_W      = $clog2(MAX_RELOAD + 1);

  timerStrobes_t      strobes;
  logic               reqEnable;
  logic               holdBit;
  logic [LATCH_W-1:0] latchVal;
  logic [CNT_W-1:0]   countVal;
  logic               pendingFlag;

  cpu_cycle_irq_timer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(LATCH_W),
    .LATCH_OFS(LATCH_OFS), .CTRL_OFS(CTRL_OFS), .ACK_OFS(ACK_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuTick(cpuTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .reqEnable(reqEnable), .holdBit(holdBit)
  );

  cpu_cycle_irq_timer_dp #(
    .LATCH_W(LATCH_W), .SCALE_SH(SCALE_SH), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .latchVal(latchVal), .countVal(countVal), .pendingFlag(pendingFlag)
  );

  assign irqReq = pendingFlag & reqEnable;

endmodule

// File: rtl/cpu_cycle_irq_timer_chk.sv
module cpu_cycle_irq_timer_chk #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned LATCH_W  = 8,
  parameter int unsigned SCALE_SH = 4,
  parameter int unsigned CNT_W    = 13,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 4'hE,
  parameter logic [ADDR_W-1:0] ACK_OFS  = 4'hF
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuTick,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [LATCH_W-1:0] wrData,
  input logic               irqReq,
  input logic [LATCH_W-1:0] latchVal,
  input logic [CNT_W-1:0]   countVal,
  input logic               pendingFlag,
  input logic               holdBit
);

  localparam int unsigned MAX_RELOAD = ((1 << LATCH_W) + 1) << SCALE_SH;

  // Independent model of both reload formulas.
  int unsigned stopExp;
  int unsigned ackExp;
  always_comb begin
    stopExp = (latchVal == '0) ? ((1 << SCALE_SH) + 1) : ((int'(latchVal) + 2) * (1 << SCALE_SH));
    ackExp  = (latchVal == '0) ? 1 : ((int'(latchVal) + 1) * (1 << SCALE_SH));
  end

  p_stop_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == CTRL_OFS && !wrData[0]) |=> (int'(countVal) == $past(stopExp)));

  p_ack_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ACK_OFS) |=> (int'(countVal) == $past(ackExp)));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ACK_OFS) |=> !irqReq);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    int'(countVal) <= MAX_RELOAD);

  p_idle_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuTick && !wrEn) |=> $stable(countVal));

  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (holdBit && !wrEn) |=> $stable(countVal));

  p_expire_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendingFlag) |-> (countVal == '0));

  p_mask_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == CTRL_OFS && !wrData[1]) |=> !irqReq);

endmodule

bind cpu_cycle_irq_timer cpu_cycle_irq_timer_chk #(
  .ADDR_W(ADDR_W), .LATCH_W(LATCH_W), .SCALE_SH(SCALE_SH), .CNT_W(CNT_W),
  .CTRL_OFS(CTRL_OFS), .ACK_OFS(ACK_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .cpuTick(cpuTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .irqReq(irqReq), .latchVal(latchVal), .countVal(countVal),
  .pendingFlag(pendingFlag), .holdBit(holdBit)
);

// File: tb/cpu_cycle_irq_timer_test.sv
`timescale 1ns/1ps
module cpu_cycle_irq_timer_test;

  localparam logic [3:0] OFS_LATCH = 4'hD;
  localparam logic [3:0] OFS_CTRL  = 4'hE;
  localparam logic [3:0] OFS_ACK   = 4'hF;

  typedef struct packed {
    logic [7:0]  lat;
    logic        useAck;  // 1: reload by acknowledge, 0: reload by stopping
    logic [12:0] delay;   // expected edges from reloading write to request
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{8'd0,   1'b1, 13'd1},
    '{8'd0,   1'b0, 13'd17},
    '{8'd1,   1'b1, 13'd32},
    '{8'd1,   1'b0, 13'd48},
    '{8'd3,   1'b1, 13'd64},
    '{8'd5,   1'b0, 13'd112},
    '{8'd16,  1'b1, 13'd272},
    '{8'd255, 1'b1, 13'd4096},
    '{8'd255, 1'b0, 13'd4112}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       irqReq;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  cpu_cycle_irq_timer uut (
    .clk(clk), .rstN(rstN), .cpuTick(cpuTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .irqReq(irqReq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    applied++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge.
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic edgesToIrq(input int start, output int n);
    n = start;
    while (!irqReq && n < 6000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: quiet after reset, and mask alone raises nothing
    chk("R1 reset irq", int'(irqReq), 0);
    cpuTick = 1'b1;
    wr(OFS_CTRL, 8'h02);
    repeat (20) @(negedge clk);
    chk("R1 no count after reset", int'(irqReq), 0);

    // Vector table: R2 latch, R3 stop reload, R4 ack reload, R7 expiry timing, R9 lost tick
    for (int i = 0; i < NVEC; i++) begin
      wr(OFS_LATCH, VEC[i].lat);
      if (VEC[i].useAck) begin
        wr(OFS_CTRL, 8'h02);
        wr(OFS_CTRL, 8'h03);
        wr(OFS_ACK, 8'h5A);
        chk($sformatf("R4 ack clears, vec %0d", i), int'(irqReq), 0);
      end else begin
        wr(OFS_ACK, 8'h00);
        wr(OFS_CTRL, 8'h02);
        wr(OFS_CTRL, 8'h03);
        chk($sformatf("R3 low after stop reload, vec %0d", i), int'(irqReq), 0);
      end
      edgesToIrq(0, n);
      chk($sformatf("%s R7 R2 delay, vec %0d", VEC[i].useAck ? "R4" : "R3", i), n, int'(VEC[i].delay));
    end

    // R5: no count without the cycle enable
    cpuTick = 1'b0;
    wr(OFS_LATCH, 8'h00);
    wr(OFS_CTRL, 8'h02);
    wr(OFS_CTRL, 8'h03);
    wr(OFS_ACK, 8'h00);
    repeat (20) @(negedge clk);
    chk("R5 idle without tick", int'(irqReq), 0);
    cpuTick = 1'b1;
    @(negedge clk);
    chk("R5 one tick expires", int'(irqReq), 1);

    // R8: mask drops the request, unmask re-raises it, ack then one more request
    wr(OFS_CTRL, 8'h01);
    chk("R8 mask drops", int'(irqReq), 0);
    repeat (5) @(negedge clk);
    chk("R8 stays masked", int'(irqReq), 0);
    wr(OFS_CTRL, 8'h03);
    chk("R8 unmask re-raises", int'(irqReq), 1);
    wr(OFS_ACK, 8'h00);
    chk("R4 ack drops", int'(irqReq), 0);
    @(negedge clk);
    chk("R8 request in a row", int'(irqReq), 1);

    // R6: hold bit freezes counting
    wr(OFS_LATCH, 8'h01);
    wr(OFS_CTRL, 8'h07);
    wr(OFS_ACK, 8'h00);
    repeat (100) @(negedge clk);
    chk("R6 held", int'(irqReq), 0);
    wr(OFS_CTRL, 8'h03);
    edgesToIrq(0, n);
    chk("R6 resumes full count", n, 32);

    // R9: writes to other offsets and R2 latch write mid-count leave the count alone
    wr(OFS_LATCH, 8'h02);
    wr(OFS_CTRL, 8'h02);
    wr(OFS_CTRL, 8'h03);
    wr(OFS_ACK, 8'h00);
    repeat (10) @(negedge clk);
    wr(4'h0, 8'hFF);
    wr(4'h7, 8'h00);
    wr(OFS_LATCH, 8'h07);
    edgesToIrq(13, n);
    chk("R9 R2 count untouched", n, 48);
    wr(OFS_ACK, 8'h00);
    edgesToIrq(0, n);
    chk("R2 new latch used", n, 128);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule